// File: doc/BRIEF.md
# Center-Symmetric Offset Interleaving Sequencer

This block decides, one ramp period at a time, whether a constant offset is added to a repeated test stimulus during converter linearity testing. The captures with and without offset are arranged in a mirror-symmetric order. As a result, slow drift in the test environment, up to a chosen polynomial order, cancels between the two groups of captures. The residual error is then of the next higher order or above.

Software or a test controller supplies an interleaving level and pulses start. The block then holds its offset-enable output steady for each ramp period. The controller reports the end of every period with a one-cycle strobe. The offset-enable output tags each captured sample, so that a downstream histogram engine can sort samples into the with-offset and without-offset histograms. The slot index output tells the same engine where the run currently is.

The sequence for level 0 is a single no-offset slot. Each higher level appends the bitwise complement of the previous sequence, so a run at level L has 2^L slots. The bit for slot i is the parity of the binary value of i. No pattern storage is needed.

Top module: `csi_sequencer`

## Requirements
- R1: After reset, offset_en_o is 0, slot_o is 0, done_o is 0 and the block is idle.
- R2: A start_i pulse while idle latches level_i, sets slot_o to 0 and clears done_o in the next cycle. The first slot always has offset_en_o = 0.
- R3: While a run is active, slot_o rises by exactly one on each cycle with period_done_i high, and holds in every other cycle.
- R4: During a run, offset_en_o is 1 (offset added) when slot_o holds an odd number of one bits, and 0 (no offset) when it holds an even number.
- R5: A period_done_i in the last slot (index 2^L−1) ends the run. In the next cycle done_o is 1, offset_en_o is 0 and slot_o is 0, so a level-L run spans exactly 2^L slots.
- R6: A requested level above 6 is clamped to 6, which gives a 64-slot run.
- R7: A start_i pulse during an active run is ignored. The level, slot and offset continue unchanged.
- R8: A period_done_i strobe while idle is ignored. slot_o, offset_en_o and done_o stay as they were.
- R9: For L ≥ 1 the sequence holds equal numbers of 0 and 1 slots. Slot i and slot 2^L−1−i carry equal bits when L is even and opposite bits when L is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when idle |
| level_i | input | LVL_IN_W (4) | Requested interleaving level, sampled at start |
| period_done_i | input | 1 | One-cycle strobe at the end of a ramp period |
| offset_en_o | output | 1 | 1 = add the offset during the current period |
| slot_o | output | MAX_LEVEL (6) | Index of the current slot |
| done_o | output | 1 | High once the last slot has finished, until the next start |

## Verification
A corrupted slot counter shows up at once as a wrong offset_en_o in the same period. It also breaks the balance and mirror properties of R9 over the whole run. A wrong latched level or end-of-run compare shows up when done_o rises early or late, one strobe away from slot 2^L−1. A missed clamp shows up as a run that does not end after 64 slots. Every slot and offset value is compared in the cycle after its strobe, so any divergence is reported within one period of where it occurs.

// File: rtl/csi_pkg.sv
package csi_pkg;

  // Clamp a requested level into the supported range.
  function automatic int clamp_level(input int req, input int max_lvl);
    if (req > max_lvl) return max_lvl;
    return req;
  endfunction

  // Index of the final slot for a given level: 2^lvl - 1.
  function automatic int last_index(input int lvl);
    return (1 << lvl) - 1;
  endfunction

  // Number of slots in a level-lvl run.
  function automatic int slot_count(input int lvl);
    return 1 << lvl;
  endfunction

endpackage

// File: rtl/csi_level_latch.sv
module csi_level_latch #(
  parameter int MAX_LEVEL = 6,
  parameter int LVL_IN_W  = 4,
  localparam int CLVL_W   = $clog2(MAX_LEVEL + 1),
  localparam int SLOT_W   = MAX_LEVEL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_i,
  input  logic [LVL_IN_W-1:0] level_i,
  output logic [CLVL_W-1:0]   level_o,
  output logic [SLOT_W-1:0]   last_idx_o
);
  logic [CLVL_W-1:0] lvl_q;
  logic [CLVL_W-1:0] lvl_d;

  always_comb begin
    lvl_d = CLVL_W'(csi_pkg::clamp_level(int'(level_i), MAX_LEVEL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_q <= '0;
    else if (accept_i) lvl_q <= lvl_d;
  end

  assign level_o    = lvl_q;
  assign last_idx_o = SLOT_W'(csi_pkg::last_index(int'(lvl_q)));

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl_q) <= MAX_LEVEL); // R6

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(lvl_q)); // R7
endmodule

// File: rtl/csi_slot_counter.sv
module csi_slot_counter #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              advance_i,
  input  logic [SLOT_W-1:0] last_idx_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wrap_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              at_last_w;

  assign at_last_w = (slot_q == last_idx_i);
  assign wrap_o    = advance_i && at_last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_q <= '0;
    else if (clear_i)   slot_q <= '0;
    else if (wrap_o)    slot_q <= '0;
    else if (advance_i) slot_q <= SLOT_W'(slot_q + 1'b1);
  end

  assign slot_o = slot_q;

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance_i && !clear_i) |=> $stable(slot_q)); // R3

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !at_last_w && !clear_i) |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1))); // R3

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (slot_q == '0)); // R5
endmodule

// File: rtl/csi_parity_bit.sv
module csi_parity_bit #(
  parameter int SLOT_W = 6
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic              bit_o
);
  logic [SLOT_W-1:0] chain_w;

  assign chain_w[0] = slot_i[0];
  for (genvar k = 1; k < SLOT_W; k++) begin : g_chain
    assign chain_w[k] = chain_w[k-1] ^ slot_i[k];
  end

  assign bit_o = chain_w[SLOT_W-1];
endmodule

// File: rtl/csi_sequencer.sv
module csi_sequencer #(
  parameter int MAX_LEVEL = 6,
  parameter int LVL_IN_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LVL_IN_W-1:0]  level_i,
  input  logic                 period_done_i,
  output logic                 offset_en_o,
  output logic [MAX_LEVEL-1:0] slot_o,
  output logic                 done_o
);
  localparam int SLOT_W = MAX_LEVEL;
  localparam int CLVL_W = $clog2(MAX_LEVEL + 1);

  logic              running_q;
  logic              done_q;
  logic              accept_w;
  logic              advance_w;
  logic              finish_w;
  logic              parity_w;
  logic [CLVL_W-1:0] level_w;
  logic [SLOT_W-1:0] last_idx_w;
  logic [SLOT_W-1:0] slot_w;

  assign accept_w  = start_i && !running_q;
  assign advance_w = period_done_i && running_q;

  csi_level_latch #(.MAX_LEVEL(MAX_LEVEL), .LVL_IN_W(LVL_IN_W)) u_level (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .level_i(level_i),
    .level_o(level_w), .last_idx_o(last_idx_w));

  csi_slot_counter #(.SLOT_W(SLOT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_w), .advance_i(advance_w),
    .last_idx_i(last_idx_w), .slot_o(slot_w), .wrap_o(finish_w));

  csi_parity_bit #(.SLOT_W(SLOT_W)) u_parity (
    .slot_i(slot_w), .bit_o(parity_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (accept_w) begin
      running_q <= 1'b1;
      done_q    <= 1'b0;
    end else if (finish_w) begin
      running_q <= 1'b0;
      done_q    <= 1'b1;
    end
  end

  assign offset_en_o = running_q && parity_w;
  assign slot_o      = slot_w;
  assign done_o      = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (!offset_en_o && slot_o == '0)); // R5

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && running_q)); // R5

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (running_q && !done_q && slot_o == '0 && !offset_en_o)); // R2

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && start_i && !period_done_i) |=> (running_q && $stable(slot_o))); // R7

  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && period_done_i && !start_i) |=> (!running_q && $stable(done_o))); // R8

  AST_OFFSET_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !advance_w) |=> $stable(offset_en_o)); // R4

  AST_OFFSET_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_w && !finish_w && !slot_w[0]) |=> (offset_en_o != $past(offset_en_o))); // R4
endmodule

// File: tb/csi_sequencer_test.sv
module csi_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] level_i = '0;
  logic       period_done_i = 1'b0;
  logic       offset_en_o;
  logic [5:0] slot_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  csi_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
    .period_done_i(period_done_i), .offset_en_o(offset_en_o),
    .slot_o(slot_o), .done_o(done_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference sequence built by repeated complement-append.
  function automatic bit ref_bit(input int lvl, input int idx);
    bit seq [64];
    seq[0] = 1'b0;
    for (int lv = 0; lv < lvl; lv++)
      for (int i = 0; i < (1 << lv); i++) seq[(1 << lv) + i] = ~seq[i];
    return seq[idx];
  endfunction

  task automatic pulse_start(input int lvl);
    @(negedge clk); level_i = 4'(lvl); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); period_done_i = 1'b1;
    @(negedge clk); period_done_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 offset", offset_en_o, 0);
    check("R1 slot", slot_o, 0);
    check("R1 done", done_o, 0);
  endtask

  task automatic t_run(input int req_lvl);
    int lvl = (req_lvl > 6) ? 6 : req_lvl;
    int n = 1 << lvl;
    bit obs [64];
    int ones = 0;
    pulse_start(req_lvl);
    check("R2 done cleared", done_o, 0);
    check("R2 first offset", offset_en_o, 0);
    for (int i = 0; i < n; i++) begin
      check("R3 slot", slot_o, i);
      check("R4 offset", offset_en_o, ref_bit(lvl, i));
      obs[i] = offset_en_o;
      ones += offset_en_o;
      if (i < n - 1) check("R5 not done yet", done_o, 0);
      pulse_done();
    end
    check("R5 done", done_o, 1);
    check("R5 offset idle", offset_en_o, 0);
    check("R5 slot idle", slot_o, 0);
    if (req_lvl > 6) check("R6 clamped length", n, 64);
    if (lvl >= 1) begin
      check("R9 balance", ones, n / 2);
      for (int i = 0; i < n / 2; i++)
        check("R9 mirror", obs[i] ^ obs[n - 1 - i], lvl % 2);
    end
  endtask

  task automatic t_hold();
    pulse_start(3);
    pulse_done(); pulse_done(); pulse_done();
    repeat (4) @(negedge clk);
    check("R3 hold slot", slot_o, 3);
    check("R4 hold offset", offset_en_o, 0);
    // start during run, level change attempt
    pulse_start(0);
    check("R7 slot kept", slot_o, 3);
    check("R7 done low", done_o, 0);
    for (int i = 3; i < 8; i++) pulse_done();
    check("R7 level kept, done after 8", done_o, 1);
  endtask

  task automatic t_idle_strobe();
    pulse_done(); pulse_done();
    check("R8 done kept", done_o, 1);
    check("R8 slot kept", slot_o, 0);
    check("R8 offset kept", offset_en_o, 0);
  endtask

  initial begin
    #2_000_000ns;
    fails++;
    checks++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_run(0);
    t_idle_strobe();
    t_run(1);
    t_run(2);
    t_run(3);
    t_run(6);
    t_hold();
    t_run(9);
    t_run(15);
    t_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule